// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block drives the processor side of a handshake with an external coprocessor. It covers five operations: load into the coprocessor, store out of the coprocessor, register move to the coprocessor, register move from the coprocessor, and a coprocessor-internal data operation. A pulse on `start` is accepted only while the block is idle. The block first checks the coprocessor number against a permission vector. It then announces phases on `cp_phase` and reads the coprocessor's answer on `cp_resp` in the same cycle. For the two memory operations it produces word addresses and memory strobes.

While the coprocessor answers BUSY, the sequencer inserts one idle cycle and asks again. During that idle cycle a small priority check looks at the reset, fast-interrupt and normal-interrupt requests. A qualifying request makes the block abandon the instruction with an interrupt phase. Every ending of an operation is reported with one `done` pulse. That pulse can come with an undefined-instruction request, a coprocessor abort, a data abort, an interrupt take or a move result. The coprocessor, the memory and the exception vectors live outside the block.

Top module: `cop_handshake_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `base_wb`, `icycle`, `ccycle` and every exception output are low, and `cp_phase` is 0 (none).
- R2: Take a start accepted while idle. If the `cp_allow` bit selected by `cp_num` is clear, the next cycle shows `undef_exc` and `done` and no phase. If that bit is set, the next cycle shows `cp_phase` = 1 (first). Operation codes: 0 load, 1 store, 2 move-to, 3 move-from, 4 data.
- R3: A BUSY answer (`cp_resp` = 1) to a first (1) or busy (2) phase is followed by exactly one cycle with `icycle` high and `cp_phase` 0, then by a busy phase (2).
- R4: If the interrupt check finds a request during that idle cycle, the next cycle shows `cp_phase` = 3 (interrupt) with `irq_take` and `done`. No memory cycle, move cycle or further phase belongs to that instruction.
- R5: Requests count only while `exc_pending` is high. A low `rst_req_n` wins (`irq_kind` 0). Next is a low `fiq_n` with `fiq_mask` clear (kind 1). Last is a low `irq_n` with `irq_mask` clear (kind 2).
- R6: A CANT answer (`cp_resp` = 2) to a first or busy phase ends the operation in the next cycle with `done`. Operations 2, 3 and 4 raise `undef_exc`. Operations 0 and 1 raise `cp_abort`.
- R7: A load accepted with READY (0) or INC (3) shows one transfer phase (4). Then come data phases (5). Data phase k reads `mem_addr` = `base_addr` + 4k and passes `mem_rdata` on `cp_wdata`. INC on a data phase adds a word and READY ends the transfer. `done` follows one cycle after the last data phase.
- R8: A store shows no transfer phase. Data phase k writes `cp_rdata` to `mem_addr` = `base_addr` + 4k with `mem_we` high. The INC and READY rules are the same as for a load.
- R9: `base_wb` pulses exactly once, in the first memory cycle, when `wb_en` was high at start. It never pulses otherwise.
- R10: A successful move-to shows `src_data` on `cp_wdata` during its first and busy phases. It then spends one cycle with `ccycle` high, followed by `done`.
- R11: A successful move-from spends one `ccycle` cycle, then one `icycle` cycle. It then shows `done` and `result_valid`, with `result` equal to the `cp_rdata` seen with the accepting answer.
- R12: An accepted data operation ends with `done` in the next cycle, without `ccycle`. After every `done` the block is idle.
- R13: `mem_abort` high in any memory cycle of a load or store gives `data_abort` together with the final `done`. There is no `data_abort` without it.
- R14: A move-from ending in CANT shows `result_valid`, with `result` holding `cc_flags` in its top bits and zeros below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_sel | input | 3 | Operation code |
| cp_num | input | log2(NUM_CP) | Coprocessor number |
| wb_en | input | 1 | Request base writeback after first memory word |
| base_addr | input | ADDR_W | First transfer address |
| src_data | input | DATA_W | Register value for a move-to |
| cc_flags | input | CC_W | Condition flags returned on a refused move-from |
| cp_allow | input | NUM_CP | Per-coprocessor access permission |
| exc_pending | input | 1 | Exception requests may be considered |
| rst_req_n | input | 1 | Reset request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| fiq_mask | input | 1 | Fast interrupt disable |
| irq_mask | input | 1 | Normal interrupt disable |
| cp_phase | output | 3 | Phase shown to the coprocessor |
| cp_resp | input | 2 | Coprocessor answer for the current phase |
| cp_wdata | output | DATA_W | Data to the coprocessor |
| cp_rdata | input | DATA_W | Data from the coprocessor |
| mem_req | output | 1 | Memory cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_abort | input | 1 | Memory abort for the current cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation ends this cycle |
| undef_exc | output | 1 | Undefined-instruction request |
| cp_abort | output | 1 | Coprocessor abort for a refused load or store |
| data_abort | output | 1 | Deferred memory abort |
| irq_take | output | 1 | Instruction abandoned for an interrupt |
| irq_kind | output | 2 | Kind of request taken |
| base_wb | output | 1 | Base writeback strobe |
| icycle | output | 1 | Internal cycle |
| ccycle | output | 1 | Coprocessor cycle |
| result | output | DATA_W | Move-from result |
| result_valid | output | 1 | Result is valid this cycle |

## Verification
The sweep covers every operation code crossed with zero to two BUSY answers, a READY or CANT final answer, and zero to two INC answers for the memory operations. The BUSY count shows up in the idle-cycle total and the latency. INC separates the one-word transfer from the multi-word one, and it shows whether each address advances by four. All 64 settings of the six interrupt inputs run against a stalled data operation, which tells apart the three priorities, the masks and the pending gate. Separate denied-access runs and abort runs, with and without CANT, show whether the refusal paths and the deferred abort take precedence correctly.

// File: rtl/cph_pkg.sv
package cph_pkg;

   typedef enum logic [2:0] {
      OP_LOAD      = 3'd0,
      OP_STORE     = 3'd1,
      OP_MOVE_TO   = 3'd2,
      OP_MOVE_FROM = 3'd3,
      OP_DATA      = 3'd4
   } cph_op_e;

   typedef enum logic [2:0] {
      PH_NONE  = 3'd0,
      PH_FIRST = 3'd1,
      PH_BUSY  = 3'd2,
      PH_INTR  = 3'd3,
      PH_XFER  = 3'd4,
      PH_DATA  = 3'd5
   } cph_phase_e;

   typedef enum logic [1:0] {
      RS_READY = 2'd0,
      RS_BUSY  = 2'd1,
      RS_CANT  = 2'd2,
      RS_INC   = 2'd3
   } cph_resp_e;

   typedef enum logic [1:0] {
      IK_RESET  = 2'd0,
      IK_FAST   = 2'd1,
      IK_NORMAL = 2'd2
   } cph_kind_e;

   typedef enum logic [3:0] {
      S_IDLE, S_DENY, S_FIRST, S_WAIT, S_BUSYPH, S_INTR, S_FAIL,
      S_XFER, S_LDATA, S_SDATA, S_CCYC, S_ICYC, S_END
   } cph_state_e;

endpackage

// File: rtl/cph_irq_arb.sv
module cph_irq_arb
   import cph_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      exc_pending,
   input  logic      rst_req_n,
   input  logic      fiq_n,
   input  logic      irq_n,
   input  logic      fiq_mask,
   input  logic      irq_mask,
   output logic      take,
   output cph_kind_e kind
);

   logic want_rst, want_fiq, want_irq;

   assign want_rst = !rst_req_n;
   assign want_fiq = !fiq_n && !fiq_mask;
   assign want_irq = !irq_n && !irq_mask;

   always_comb begin
      take = 1'b0;
      kind = IK_NORMAL;
      if (exc_pending) begin
         if (want_rst) begin
            take = 1'b1;
            kind = IK_RESET;
         end else if (want_fiq) begin
            take = 1'b1;
            kind = IK_FAST;
         end else if (want_irq) begin
            take = 1'b1;
            kind = IK_NORMAL;
         end
      end
   end

   // R5: no request is granted unless the pending gate is open
   assert_take_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> exc_pending);

endmodule

// File: rtl/cph_addr_gen.sv
module cph_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int STEP_BYTES = 4,
   parameter bit ALIGN_BASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);

   localparam int LSB_W = $clog2(STEP_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

   if (STEP_BYTES < 2 || (STEP_BYTES & (STEP_BYTES - 1)) != 0) begin : g_bad_step
      $error("cph_addr_gen: STEP_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= LSB_W) begin : g_bad_width
      $error("cph_addr_gen: ADDR_W too small for STEP_BYTES");
   end

   logic [ADDR_W-1:0] base_eff;

   if (ALIGN_BASE) begin : g_align
      assign base_eff = {base[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
   end else begin : g_raw
      assign base_eff = base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= base_eff;
      else if (step)
         addr <= addr + STEP;
   end

   // R7: every accepted continuation moves exactly one word forward
   assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr == $past(addr) + STEP));

endmodule

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq
   import cph_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int NUM_CP = 16,
   parameter int CC_W   = 4,
   parameter int CPN_W  = $clog2(NUM_CP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic [CPN_W-1:0]  cp_num,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DATA_W-1:0] src_data,
   input  logic [CC_W-1:0]   cc_flags,
   input  logic [NUM_CP-1:0] cp_allow,
   input  logic              exc_pending,
   input  logic              rst_req_n,
   input  logic              fiq_n,
   input  logic              irq_n,
   input  logic              fiq_mask,
   input  logic              irq_mask,
   output logic [2:0]        cp_phase,
   input  logic [1:0]        cp_resp,
   output logic [DATA_W-1:0] cp_wdata,
   input  logic [DATA_W-1:0] cp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_abort,
   output logic              busy,
   output logic              done,
   output logic              undef_exc,
   output logic              cp_abort,
   output logic              data_abort,
   output logic              irq_take,
   output logic [1:0]        irq_kind,
   output logic              base_wb,
   output logic              icycle,
   output logic              ccycle,
   output logic [DATA_W-1:0] result,
   output logic              result_valid
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int PAD_W      = DATA_W - CC_W;

   if (NUM_CP < 2 || (1 << CPN_W) != NUM_CP) begin : g_bad_cp
      $error("cop_handshake_seq: NUM_CP must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0 || DATA_W <= CC_W) begin : g_bad_data
      $error("cop_handshake_seq: DATA_W must be whole bytes and wider than CC_W");
   end

   cph_state_e st, nxt, accept_nxt;
   cph_op_e    op_q;
   cph_resp_e  resp;
   cph_kind_e  kind_w, kind_q;
   logic       take_w;
   logic       wb_q, first_q, abort_q;
   logic [DATA_W-1:0] src_q, result_q;
   logic       addr_load, addr_step, handshake;

   assign resp      = cph_resp_e'(cp_resp);
   assign handshake = (st == S_FIRST) || (st == S_BUSYPH);

   cph_irq_arb u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .exc_pending (exc_pending),
      .rst_req_n   (rst_req_n),
      .fiq_n       (fiq_n),
      .irq_n       (irq_n),
      .fiq_mask    (fiq_mask),
      .irq_mask    (irq_mask),
      .take        (take_w),
      .kind        (kind_w)
   );

   assign addr_load = (st == S_IDLE) && start;
   assign addr_step = mem_req && (resp == RS_INC);

   cph_addr_gen #(
      .ADDR_W     (ADDR_W),
      .STEP_BYTES (WORD_BYTES),
      .ALIGN_BASE (1'b1)
   ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (addr_load),
      .base  (base_addr),
      .step  (addr_step),
      .addr  (mem_addr)
   );

   // where an accepting answer leads, per operation
   always_comb begin
      unique case (op_q)
         OP_LOAD:      accept_nxt = S_XFER;
         OP_STORE:     accept_nxt = S_SDATA;
         OP_MOVE_TO,
         OP_MOVE_FROM: accept_nxt = S_CCYC;
         default:      accept_nxt = S_END;
      endcase
   end

   always_comb begin
      nxt = st;
      unique case (st)
         S_IDLE:   if (start) nxt = cp_allow[cp_num] ? S_FIRST : S_DENY;
         S_FIRST,
         S_BUSYPH: begin
            if (resp == RS_BUSY)      nxt = S_WAIT;
            else if (resp == RS_CANT) nxt = S_FAIL;
            else                      nxt = accept_nxt;
         end
         S_WAIT:   nxt = take_w ? S_INTR : S_BUSYPH;
         S_XFER:   nxt = S_LDATA;
         S_LDATA,
         S_SDATA:  nxt = (resp == RS_INC) ? st : S_END;
         S_CCYC:   nxt = (op_q == OP_MOVE_FROM) ? S_ICYC : S_END;
         S_ICYC:   nxt = S_END;
         default:  nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op_q     <= OP_DATA;
         wb_q     <= 1'b0;
         first_q  <= 1'b0;
         abort_q  <= 1'b0;
         src_q    <= '0;
         result_q <= '0;
         kind_q   <= IK_RESET;
      end else begin
         st <= nxt;
         if (addr_load) begin
            op_q    <= cph_op_e'(op_sel);
            wb_q    <= wb_en;
            src_q   <= src_data;
            first_q <= 1'b1;
            abort_q <= 1'b0;
         end
         if (mem_req) begin
            first_q <= 1'b0;
            if (mem_abort) abort_q <= 1'b1;
         end
         if (handshake && op_q == OP_MOVE_FROM &&
             (resp == RS_READY || resp == RS_INC))
            result_q <= cp_rdata;
         if (st == S_WAIT && take_w)
            kind_q <= kind_w;
      end
   end

   // phase and strobe decode
   always_comb begin
      unique case (st)
         S_FIRST:         cp_phase = PH_FIRST;
         S_BUSYPH:        cp_phase = PH_BUSY;
         S_INTR:          cp_phase = PH_INTR;
         S_XFER:          cp_phase = PH_XFER;
         S_LDATA, S_SDATA: cp_phase = PH_DATA;
         default:         cp_phase = PH_NONE;
      endcase
   end

   always_comb begin
      if (st == S_LDATA)
         cp_wdata = mem_rdata;
      else if (handshake && op_q == OP_MOVE_TO)
         cp_wdata = src_q;
      else
         cp_wdata = '0;
   end

   assign busy       = (st != S_IDLE);
   assign mem_req    = (st == S_LDATA) || (st == S_SDATA);
   assign mem_we     = (st == S_SDATA);
   assign mem_wdata  = (st == S_SDATA) ? cp_rdata : '0;
   assign base_wb    = mem_req && first_q && wb_q;
   assign icycle     = (st == S_WAIT) || (st == S_ICYC);
   assign ccycle     = (st == S_CCYC);
   assign done       = (st == S_DENY) || (st == S_INTR) ||
                       (st == S_FAIL) || (st == S_END);
   assign undef_exc  = (st == S_DENY) ||
                       ((st == S_FAIL) && op_q != OP_LOAD && op_q != OP_STORE);
   assign cp_abort   = (st == S_FAIL) && (op_q == OP_LOAD || op_q == OP_STORE);
   assign data_abort = (st == S_END) && abort_q;
   assign irq_take   = (st == S_INTR);
   assign irq_kind   = kind_q;
   assign result_valid = ((st == S_END) || (st == S_FAIL)) && op_q == OP_MOVE_FROM;
   assign result     = (st == S_FAIL) ? {cc_flags, {PAD_W{1'b0}}} : result_q;

   // R2: a first phase appears only right after an accepted start
   assert_first_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_FIRST) |-> $past(start && !busy));

   // R3: a busy phase is always preceded by a quiet idle cycle
   assert_busy_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_BUSY) |-> $past(icycle && cp_phase == PH_NONE));

   // R4: abandonment happens only out of an idle cycle and ends the operation
   assert_intr_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> ($past(icycle) && done));

   // R6: at most one kind of ending is reported
   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({undef_exc, cp_abort, data_abort, irq_take}) <= 1);

   // R9: writeback strobe never repeats in the next cycle
   assert_wb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      base_wb |=> !base_wb);

   // R12: every done returns the block to idle
   assert_done_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R13: a deferred abort is reported only with the final done
   assert_abort_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
      data_abort |-> (done && $past(busy)));

endmodule

// File: tb/tb_cop_handshake_seq.sv
module tb_cop_handshake_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [2:0]  op_sel;
   logic [3:0]  cp_num;
   logic        wb_en;
   logic [31:0] base_addr;
   logic [31:0] src_data;
   logic [3:0]  cc_flags;
   logic [15:0] cp_allow;
   logic        exc_pending, rst_req_n, fiq_n, irq_n, fiq_mask, irq_mask;
   logic [2:0]  cp_phase;
   logic [1:0]  cp_resp;
   logic [31:0] cp_wdata, cp_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_abort;
   logic        busy, done, undef_exc, cp_abort, data_abort, irq_take;
   logic [1:0]  irq_kind;
   logic        base_wb, icycle, ccycle;
   logic [31:0] result;
   logic        result_valid;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   cop_handshake_seq #(.ADDR_W(32), .DATA_W(32), .NUM_CP(16), .CC_W(4)) dut (.*);

   always #5 clk = ~clk;

   // behavioural coprocessor and memory
   int busy_cfg = 0, inc_cfg = 0;
   int busy_seen = 0, data_seen = 0;
   logic [1:0] fin_resp = 2'd0;

   always @(posedge clk) begin
      if (start) begin
         busy_seen <= 0;
         data_seen <= 0;
      end else begin
         if ((cp_phase == 3'd1 || cp_phase == 3'd2) && cp_resp == 2'd1) busy_seen <= busy_seen + 1;
         if (cp_phase == 3'd5) data_seen <= data_seen + 1;
      end
   end

   always_comb begin
      if (cp_phase == 3'd1 || cp_phase == 3'd2)
         cp_resp = (busy_seen < busy_cfg) ? 2'd1 : fin_resp;
      else if (cp_phase == 3'd5)
         cp_resp = (data_seen < inc_cfg) ? 2'd3 : 2'd0;
      else
         cp_resp = 2'd0;
   end

   assign cp_rdata  = (cp_phase == 3'd5) ? 32'hA500_0000 + 32'(data_seen)
                                         : 32'h1234_5600 | 32'(busy_cfg);
   assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int op, input bit allow, input int busyn, input bit cant,
                         input int inc, input bit wb, input bit abrt, input logic [5:0] irqv);
      int ncyc = 0, nfirst = 0, nbph = 0, nintr = 0, nxfer = 0, ndata = 0;
      int nic = 0, ncc = 0, nmem = 0, nrd = 0, nwr = 0, nwb = 0, bad = 0, wbbad = 0, mvbad = 0;
      logic g_und = 0, g_cpa = 0, g_dab = 0, g_tk = 0, g_rv = 0;
      logic [1:0] g_kind = 0;
      logic [31:0] g_res = 0;
      bit pend, intr;
      int kind_e, cyc_e, ic_e;
      logic [31:0] base = 32'h0000_0200;
      logic [31:0] src  = 32'hC0DE_0000 + 32'(op);
      @(negedge clk);
      op_sel = 3'(op); cp_num = 4'd6; cp_allow = allow ? 16'hFFFF : ~16'h0040;
      wb_en = wb; base_addr = base; src_data = src; cc_flags = 4'hA;
      busy_cfg = busyn; inc_cfg = inc; fin_resp = cant ? 2'd2 : 2'd0; mem_abort = abrt;
      {exc_pending, rst_req_n, fiq_n, irq_n, fiq_mask, irq_mask} = irqv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 1; cyc <= 100; cyc++) begin
         ncyc = cyc;
         case (cp_phase)
            3'd1: nfirst++;
            3'd2: nbph++;
            3'd3: nintr++;
            3'd4: nxfer++;
            3'd5: ndata++;
            default: ;
         endcase
         if (icycle) begin
            nic++;
            if (cp_phase != 3'd0) bad++;
         end
         if (ccycle) ncc++;
         if ((cp_phase == 3'd1 || cp_phase == 3'd2) && op == 2 && cp_wdata !== src) mvbad++;
         if (base_wb && (!mem_req || nmem != 0)) wbbad++;
         if (base_wb) nwb++;
         if (mem_req) begin
            if (mem_addr !== base + 32'(4 * nmem)) bad++;
            if (mem_we) begin
               nwr++;
               if (mem_wdata !== 32'hA500_0000 + 32'(nmem)) bad++;
            end else begin
               nrd++;
               if (cp_wdata !== (mem_addr ^ 32'h5A5A_0000)) bad++;
            end
            nmem++;
         end
         if (done) begin
            g_und = undef_exc; g_cpa = cp_abort; g_dab = data_abort; g_tk = irq_take;
            g_kind = irq_kind; g_res = result; g_rv = result_valid;
            break;
         end
         @(negedge clk);
      end

      pend = irqv[5] && (!irqv[4] || (!irqv[3] && !irqv[1]) || (!irqv[2] && !irqv[0]));
      kind_e = !irqv[4] ? 0 : (!irqv[3] && !irqv[1]) ? 1 : 2;
      intr = allow && pend && busyn > 0;

      if (!allow) begin
         chk("R2", "deny undef", 32'(g_und), 1);
         chk("R2", "deny phases", 32'(nfirst + nbph + ndata + nxfer), 0);
         chk("R2", "deny latency", 32'(ncyc), 1);
      end else if (intr) begin
         chk("R4", "intr phase", 32'(nintr), 1);
         chk("R4", "intr take", 32'(g_tk), 1);
         chk("R4", "intr no busy phase", 32'(nbph + nmem + ncc), 0);
         chk("R4", "intr latency", 32'(ncyc), 3);
         chk("R5", "intr kind", 32'(g_kind), 32'(kind_e));
      end else begin
         case (op)
            0: cyc_e = cant ? 1 : inc + 3;
            1: cyc_e = cant ? 1 : inc + 2;
            2: cyc_e = cant ? 1 : 2;
            3: cyc_e = cant ? 1 : 3;
            default: cyc_e = 1;
         endcase
         cyc_e = cyc_e + 1 + 2 * busyn;
         ic_e = busyn + ((op == 3 && !cant) ? 1 : 0);
         chk("R2", "first phase", 32'(nfirst), 1);
         chk("R3", "busy phases", 32'(nbph), 32'(busyn));
         chk("R3", "idle cycles", 32'(nic), 32'(ic_e));
         chk("R4", "no take", 32'(g_tk + nintr), 0);
         chk("R12", "latency", 32'(ncyc), 32'(cyc_e));
         chk("R6", "undef", 32'(g_und), 32'(cant && op >= 2));
         chk("R6", "cp abort", 32'(g_cpa), 32'(cant && op <= 1));
         chk("R7", "transfer phase", 32'(nxfer), 32'(op == 0 && !cant));
         chk("R7", "load reads", 32'(nrd), (op == 0 && !cant) ? 32'(inc + 1) : 0);
         chk("R8", "store writes", 32'(nwr), (op == 1 && !cant) ? 32'(inc + 1) : 0);
         chk("R8", "addr and data", 32'(bad), 0);
         chk("R9", "wb count", 32'(nwb), 32'(op <= 1 && !cant && wb));
         chk("R9", "wb position", 32'(wbbad), 0);
         chk("R10", "move cycles", 32'(ncc), 32'((op == 2 || op == 3) && !cant));
         chk("R10", "move-to data", 32'(mvbad), 0);
         chk("R13", "data abort", 32'(g_dab), 32'(abrt && op <= 1 && !cant));
         chk("R11", "result valid", 32'(g_rv), 32'(op == 3));
         if (op == 3)
            chk(cant ? "R14" : "R11", "result", g_res,
                cant ? 32'hA000_0000 : (32'h1234_5600 | 32'(busyn)));
      end
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; op_sel = '0; cp_num = '0; wb_en = 1'b0;
      base_addr = '0; src_data = '0; cc_flags = '0; cp_allow = '1;
      exc_pending = 1'b0; rst_req_n = 1'b1; fiq_n = 1'b1; irq_n = 1'b1;
      fiq_mask = 1'b0; irq_mask = 1'b0; mem_abort = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "reset outputs", {busy, done, mem_req, base_wb, icycle, ccycle,
          undef_exc, cp_abort, data_abort, irq_take, cp_phase}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", {busy, done, cp_phase}, 0);

      // main sweep: operation x busy count x final answer x word count
      for (int op = 0; op <= 4; op++)
         for (int b = 0; b <= 2; b++)
            for (int c = 0; c <= 1; c++)
               for (int n = 0; n <= ((op <= 1) ? 2 : 0); n++)
                  run_op(op, 1'b1, b, c[0], n, (b == 1), 1'b0, 6'b010000);

      // permission refused for every operation
      for (int op = 0; op <= 4; op++)
         run_op(op, 1'b0, 1, 1'b0, 0, 1'b1, 1'b0, 6'b010000);

      // interrupt check sweep on a stalled data operation
      for (int v = 0; v < 64; v++)
         run_op(4, 1'b1, 1, 1'b0, 0, 1'b0, 1'b0, 6'(v));

      // deferred memory abort, with and without refusal
      run_op(0, 1'b1, 0, 1'b0, 2, 1'b1, 1'b1, 6'b010000);
      run_op(1, 1'b1, 1, 1'b0, 2, 1'b0, 1'b1, 6'b010000);
      run_op(0, 1'b1, 0, 1'b1, 2, 1'b0, 1'b1, 6'b010000);
      run_op(1, 1'b1, 0, 1'b1, 0, 1'b0, 1'b1, 6'b010000);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule